// File: doc/BRIEF.md
# Directory Home Controller for Point-to-Point Coherence

This block is the home side of a directory coherence scheme in a distributed shared-memory machine. For every memory line it owns, it keeps a small record: one presence bit for each node and a dirty flag. Requesting nodes send it read-miss and write-miss messages. The controller answers each one from that record. It replies with data from its local word array, forwards a request to the single node that holds a modified copy, or sends invalidations to the nodes that hold a copy. Messages go only to the nodes whose presence bits are set.

A write miss completes in three steps. The requester first gets the data and the vector of other sharers. The controller then sends one invalidation per cycle and counts acknowledgements down from the number of sharers. When that count and the invalidation queue are both empty, it sends a completion message. The controller runs one transaction at a time. Any request that arrives while it is busy is refused with a NACK, so the remote node retries.

Top module: `dir_home`

## Requirements
- R1: After reset no message output is valid, every line is clean with no sharers, and the word of line i holds i (truncated to the data width).
- R2: A read miss to a line that is not dirty gets a reply in the next cycle. The reply goes to the requester, carries the stored word and an all-zero sharer field, and adds the requester to the line's sharers.
- R3: A read miss to a dirty line owned by another node produces a forward in the next cycle. The forward goes to the owner, with fwd_excl=0 and the line on msg_line. When the owner returns data, the controller stores it and replies to the requester in the next cycle with that data. The line then becomes clean and is served from memory.
- R4: A write miss to a line that is not dirty gets a reply in the next cycle. The reply carries the stored word and a sharer vector in which bit i stands for node i. The vector holds every current sharer except the requester.
- R5: Invalidations of a write miss go out one per cycle, starting the cycle after the reply. Node indices go in ascending order, and the line is on msg_line. They go only to the sharers reported in R4, never to the requester.
- R6: The ack counter is loaded with the number of sharers in R4 and counts down by one per ack_valid. A completion message to the writer appears one cycle after the cycle in which the queue is empty and the count is zero. If there were no sharers, it appears two cycles after the request.
- R7: After a write completes, the line is dirty and its only sharer is the writer. A later read miss from another node is therefore forwarded to the writer.
- R8: A write miss to a line held dirty by another node produces a forward to that owner with fwd_excl=1. When the owner returns data, the controller gives a reply with that data and an empty sharer field, and the completion message, in the same cycle.
- R9: A request that arrives while a transaction is in progress gets a NACK to its sender in the next cycle and changes no directory state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_node | input | NW | Requesting node |
| req_line | input | LW | Requested line |
| own_valid | input | 1 | Data returned by a forwarded-to owner |
| own_data | input | DW | Owner's line data |
| ack_valid | input | 1 | Invalidation acknowledgement |
| ack_node | input | NW | Node sending the acknowledgement |
| rep_valid | output | 1 | Data reply to the requester |
| rep_node | output | NW | Reply destination |
| rep_data | output | DW | Reply data |
| rep_sharers | output | NODES | Other sharers (write miss), else zero |
| fwd_valid | output | 1 | Forward to the owner |
| fwd_node | output | NW | Owner node |
| fwd_excl | output | 1 | 1 = owner must drop its copy, 0 = keep it shared |
| inv_valid | output | 1 | Invalidation message |
| inv_node | output | NW | Invalidation destination |
| msg_line | output | LW | Line of the current transaction |
| done_valid | output | 1 | Write completion message |
| done_node | output | NW | Writer receiving completion |
| nack_valid | output | 1 | Busy refusal |
| nack_node | output | NW | Refused node |

## Verification
All outputs are registered. A reply, forward or NACK therefore appears one cycle after its request or owner return. The invalidations follow the reply in back-to-back cycles. Completion follows the cycle in which the acknowledgement count reaches zero. The bench drives inputs on the falling edge, waits exactly that number of rising edges, and samples on the next falling edge. It also checks that completion is absent in the intervening cycles, even after the last acknowledgement. Directory contents are never read directly. They are shown through later requests: the sharer vector of a later write and the forward target of a later read.

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NODES = 4,
  parameter int LINES = 8,
  parameter int DW    = 8,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES),
  localparam int CW = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NW-1:0]    req_node,
  input  logic [LW-1:0]    req_line,
  input  logic             own_valid,
  input  logic [DW-1:0]    own_data,
  input  logic             ack_valid,
  input  logic [NW-1:0]    ack_node,
  output logic             rep_valid,
  output logic [NW-1:0]    rep_node,
  output logic [DW-1:0]    rep_data,
  output logic [NODES-1:0] rep_sharers,
  output logic             fwd_valid,
  output logic [NW-1:0]    fwd_node,
  output logic             fwd_excl,
  output logic             inv_valid,
  output logic [NW-1:0]    inv_node,
  output logic [LW-1:0]    msg_line,
  output logic             done_valid,
  output logic [NW-1:0]    done_node,
  output logic             nack_valid,
  output logic [NW-1:0]    nack_node
);

  typedef enum logic [1:0] {IDLE, FWD, INV} st_t;
  st_t st;

  logic [NODES-1:0] pres [LINES];
  logic [LINES-1:0] dirty;
  logic [DW-1:0]    mem  [LINES];

  logic             cur_wr;
  logic [NW-1:0]    cur_node;
  logic [LW-1:0]    cur_line;
  logic [NODES-1:0] pend;
  logic [CW-1:0]    cnt;

  function automatic logic [NW-1:0] low_idx(input logic [NODES-1:0] v);
    low_idx = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (v[i]) low_idx = NW'(i);
  endfunction

  wire [NODES-1:0] rq_bit    = NODES'(1) << req_node;
  wire [NODES-1:0] cur_bit   = NODES'(1) << cur_node;
  wire [NODES-1:0] line_pres = pres[req_line];
  wire [NW-1:0]    owner     = low_idx(line_pres);
  wire             need_fwd  = dirty[req_line] && (owner != req_node);
  wire [NODES-1:0] others    = line_pres & ~rq_bit;
  wire [NW-1:0]    next_inv  = low_idx(pend);
  wire             inv_fin   = (pend == '0) && (cnt == '0);

  assign msg_line = cur_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      dirty       <= '0;
      pend        <= '0;
      cnt         <= '0;
      cur_wr      <= 1'b0;
      cur_node    <= '0;
      cur_line    <= '0;
      rep_valid   <= 1'b0;
      rep_node    <= '0;
      rep_data    <= '0;
      rep_sharers <= '0;
      fwd_valid   <= 1'b0;
      fwd_node    <= '0;
      fwd_excl    <= 1'b0;
      inv_valid   <= 1'b0;
      inv_node    <= '0;
      done_valid  <= 1'b0;
      done_node   <= '0;
      nack_valid  <= 1'b0;
      nack_node   <= '0;
      for (int i = 0; i < LINES; i++) begin
        pres[i] <= '0;
        mem[i]  <= DW'(i);
      end
    end else begin
      rep_valid  <= 1'b0;
      fwd_valid  <= 1'b0;
      inv_valid  <= 1'b0;
      done_valid <= 1'b0;
      nack_valid <= 1'b0;
      if (req_valid && st != IDLE) begin
        nack_valid <= 1'b1;
        nack_node  <= req_node;
      end
      case (st)
        IDLE: if (req_valid) begin
          cur_wr   <= req_write;
          cur_node <= req_node;
          cur_line <= req_line;
          if (need_fwd) begin
            fwd_valid <= 1'b1;
            fwd_node  <= owner;
            fwd_excl  <= req_write;
            st        <= FWD;
          end else begin
            rep_valid <= 1'b1;
            rep_node  <= req_node;
            rep_data  <= mem[req_line];
            if (!req_write) begin
              rep_sharers    <= '0;
              pres[req_line] <= line_pres | rq_bit;
            end else begin
              rep_sharers <= others;
              pend        <= others;
              cnt         <= CW'($countones(others));
              st          <= INV;
            end
          end
        end
        FWD: if (own_valid) begin
          mem[cur_line] <= own_data;
          rep_valid     <= 1'b1;
          rep_node      <= cur_node;
          rep_data      <= own_data;
          rep_sharers   <= '0;
          if (cur_wr) begin
            pres[cur_line]  <= cur_bit;
            dirty[cur_line] <= 1'b1;
            done_valid      <= 1'b1;
            done_node       <= cur_node;
          end else begin
            pres[cur_line]  <= pres[cur_line] | cur_bit;
            dirty[cur_line] <= 1'b0;
          end
          st <= IDLE;
        end
        INV: begin
          if (pend != '0) begin
            inv_valid <= 1'b1;
            inv_node  <= next_inv;
            pend      <= pend & ~(NODES'(1) << next_inv);
          end
          if (ack_valid && cnt != '0) cnt <= cnt - 1'b1;
          if (inv_fin) begin
            done_valid      <= 1'b1;
            done_node       <= cur_node;
            pres[cur_line]  <= cur_bit;
            dirty[cur_line] <= 1'b1;
            st              <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R5
  inv_not_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_node != cur_node);

  // R6
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && $past(st) == INV) |-> cnt == '0);

  // R9
  nack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_valid |-> ($past(req_valid) && $past(st) != IDLE));

  // R3
  fwd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> st == FWD);

  // R2
  rep_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> ($past(req_valid) || $past(own_valid)));

  // R1
  no_msg_reset_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !(rep_valid || fwd_valid || inv_valid || done_valid || nack_valid));

endmodule

// File: tb/dir_home_test.sv
module dir_home_test;
  localparam int NODES = 4, LINES = 4, DW = 8;
  localparam int NW = $clog2(NODES), LW = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [NW-1:0] req_node = '0;
  logic [LW-1:0] req_line = '0;
  logic own_valid = 0;
  logic [DW-1:0] own_data = '0;
  logic ack_valid = 0;
  logic [NW-1:0] ack_node = '0;
  logic rep_valid, fwd_valid, fwd_excl, inv_valid, done_valid, nack_valid;
  logic [NW-1:0] rep_node, fwd_node, inv_node, done_node, nack_node;
  logic [DW-1:0] rep_data;
  logic [NODES-1:0] rep_sharers;
  logic [LW-1:0] msg_line;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dir_home #(.NODES(NODES), .LINES(LINES), .DW(DW)) uut (
    .clk, .rst_n, .req_valid, .req_write, .req_node, .req_line,
    .own_valid, .own_data, .ack_valid, .ack_node,
    .rep_valid, .rep_node, .rep_data, .rep_sharers,
    .fwd_valid, .fwd_node, .fwd_excl, .inv_valid, .inv_node, .msg_line,
    .done_valid, .done_node, .nack_valid, .nack_node);

  task automatic ck(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(input bit w, input int n, input int l);
    req_valid = 1; req_write = w; req_node = NW'(n); req_line = LW'(l);
    step();
    req_valid = 0;
  endtask

  task automatic own_ret(input int d);
    own_valid = 1; own_data = DW'(d);
    step();
    own_valid = 0;
  endtask

  task automatic ck_rep(input string tag, input int n, input int d, input int sh);
    ck(tag, "rep_valid", rep_valid, 1);
    ck(tag, "rep_node", rep_node, n);
    ck(tag, "rep_data", rep_data, d);
    ck(tag, "rep_sharers", rep_sharers, sh);
  endtask

  task automatic ck_fwd(input string tag, input int n, input int x, input int l);
    ck(tag, "fwd_valid", fwd_valid, 1);
    ck(tag, "fwd_node", fwd_node, n);
    ck(tag, "fwd_excl", fwd_excl, x);
    ck(tag, "msg_line", msg_line, l);
    ck(tag, "rep_valid during forward", rep_valid, 0);
  endtask

  task automatic t_reset();
    ck("R1", "rep_valid", rep_valid, 0);
    ck("R1", "fwd_valid", fwd_valid, 0);
    ck("R1", "inv_valid", inv_valid, 0);
    ck("R1", "done_valid", done_valid, 0);
    ck("R1", "nack_valid", nack_valid, 0);
  endtask

  task automatic t_clean_read();
    send(0, 0, 1);
    ck_rep("R2", 0, 1, 0);
    send(0, 2, 1);
    ck_rep("R2", 2, 1, 0);
  endtask

  task automatic t_write_inv();
    send(1, 3, 1);
    ck_rep("R4", 3, 1, 'b0101);
    step();
    ck("R5", "inv_valid first", inv_valid, 1);
    ck("R5", "inv_node first", inv_node, 0);
    ck("R5", "msg_line", msg_line, 1);
    step();
    ck("R5", "inv_valid second", inv_valid, 1);
    ck("R5", "inv_node second", inv_node, 2);
    step();
    ck("R5", "no third inv", inv_valid, 0);
    ck("R6", "done before acks", done_valid, 0);
    ack_valid = 1; ack_node = 0;
    req_valid = 1; req_write = 0; req_node = 1; req_line = 2;
    step();
    req_valid = 0;
    ck("R9", "nack_valid", nack_valid, 1);
    ck("R9", "nack_node", nack_node, 1);
    ck("R6", "done after one ack", done_valid, 0);
    ack_node = 2;
    step();
    ack_valid = 0;
    ck("R6", "done in count-zero cycle", done_valid, 0);
    step();
    ck("R6", "done_valid", done_valid, 1);
    ck("R6", "done_node", done_node, 3);
    ck("R9", "refused request got no reply", rep_valid, 0);
  endtask

  task automatic t_dirty_read();
    send(0, 0, 1);
    ck_fwd("R7", 3, 0, 1);
    own_ret('hA5);
    ck_rep("R3", 0, 'hA5, 0);
    send(0, 1, 1);
    ck_rep("R3", 1, 'hA5, 0);
    // R9: the refused read of line 2 left line 2 without sharers
    send(1, 1, 2);
    ck_rep("R9", 1, 2, 0);
    step();
    ck("R6", "done with no sharers", done_valid, 1);
    ck("R6", "done_node", done_node, 1);
  endtask

  task automatic t_write_dirty();
    send(1, 0, 2);
    ck_fwd("R8", 1, 1, 2);
    own_ret('h3C);
    ck_rep("R8", 0, 'h3C, 0);
    ck("R8", "done_valid", done_valid, 1);
    ck("R8", "done_node", done_node, 0);
    send(0, 3, 2);
    ck_fwd("R7", 0, 0, 2);
    own_ret('h3C);
    ck_rep("R3", 3, 'h3C, 0);
  endtask

  task automatic t_self_sharer();
    send(0, 2, 3);
    ck_rep("R2", 2, 3, 0);
    send(0, 1, 3);
    ck_rep("R2", 1, 3, 0);
    send(1, 2, 3);
    ck_rep("R4", 2, 3, 'b0010);
    step();
    ck("R5", "inv to other sharer", inv_valid, 1);
    ck("R5", "inv_node", inv_node, 1);
    step();
    ck("R5", "requester not invalidated", inv_valid, 0);
    ack_valid = 1; ack_node = 1;
    step();
    ack_valid = 0;
    ck("R6", "done at count zero", done_valid, 0);
    step();
    ck("R6", "done_node", done_node, 2);
    ck("R6", "done_valid", done_valid, 1);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_clean_read();
    t_write_inv();
    t_dirty_read();
    t_write_dirty();
    t_self_sharer();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule